// File: doc/BRIEF.md
# Disk Controller Switch and Phase Decoder

This block sits behind a 16-location register window of a floppy-disk controller. Each access to the window sets or clears one controller state bit, selected by the upper three offset bits. The bit is cleared on an even offset and set on an odd offset. There are eight such bits: four stepper phase lines, a motor enable, a drive select, and two mode lines called Q6 and Q7. Every read returns a byte. Which byte depends on the motor state and on Q6 and Q7: the incoming data byte, a status byte, a handshake byte, or an internal mode register. The mode register can only be loaded while the motor is off.

When the external 3.5-inch mode input is high, the phase lines also act as a small command bus. A rising phase 3 captures a 4-bit drive command, and that command alone starts or stops the 3.5-inch motor. The lower phases and the head-select input together pick one of sixteen drive sense bits for the status byte. Two phase pairs have special meanings: phases 0 and 2 together signal a controller reset, and phases 1 and 3 together signal an auxiliary-bus enable. A software motor-off does not stop the motor at once. The motor keeps running until 60 frame-strobe ticks (one second) have passed, and touching the motor-on offset during that wait cancels it.

Top module: `sw_phase_decoder`

## Requirements
- R1: An access to offset 2k (k = 0..3) clears phase k and an access to offset 2k+1 sets it; `phaseOut[k]` shows the new value from the cycle after the access.
- R2: Offsets 10/11 clear/set `driveSel`, 12/13 clear/set `q6Out` and 14/15 clear/set `q7Out`. This happens for both reads and writes, and the new value is visible one cycle after the access.
- R3: Every read raises `rdValid` for one cycle, one cycle after the access. `rdData` is computed from the state after that access. With the motor enabled the {Q7,Q6} encoding selects the byte: 00 gives `rdByteIn`, 01 and 11 give the status byte, and 10 gives `hsByteIn`.
- R4: With the motor off, a read returns the status byte when Q6=1 and the mode register otherwise. A write to offset 15 while the motor is off and Q6=1 loads `accWdata` into the mode register. The same write with the motor enabled leaves the mode register unchanged.
- R5: The status byte has the sense bit in bit 7 and the motor enable in bit 5; all other bits are 0. In 5.25-inch mode the sense bit is `wrProtect`. In 3.5-inch mode it is `driveSense[{headSel, phase2, phase1, phase0}]`.
- R6: In 3.5-inch mode, an access that turns phase 3 from off to on pulses `cmdValid` for one cycle, with `cmdCode = {headSel, phase2, phase1, phase0}`. Neither 5.25-inch mode nor a phase 3 that is already on produces a pulse.
- R7: `ctrlReset` is high while 3.5-inch mode is set and phases 0 and 2 are both on, and while it is high the mode register is forced to 0. `auxEnable` is high while 3.5-inch mode is set and phases 1 and 3 are both on.
- R8: An access to offset 8 while the motor is enabled keeps `motorEnable` high through 59 `frameTick` pulses and drops it after the 60th.
- R9: An access to offset 9 cancels a pending motor-off. This includes an access that falls in the same cycle as the expiring tick: the cancel wins and the motor stays enabled.
- R10: `motor35Run` is set by command code 0 and cleared by command code 8. Offsets 8 and 9 have no effect on it.
- R11: After reset every state output is 0: phases, motor, drive select, Q6, Q7, mode register, `rdValid`, `cmdValid` and `motor35Run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Register-window access strobe |
| accAddr | input | 4 | Window offset |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accWdata | input | 8 | Write data |
| sel35 | input | 1 | 3.5-inch mode enable |
| headSel | input | 1 | External select bit used for commands and status selection |
| frameTick | input | 1 | 60 Hz frame strobe, one cycle wide |
| rdByteIn | input | 8 | Byte from the read serializer |
| hsByteIn | input | 8 | Handshake byte from the write serializer |
| wrProtect | input | 1 | Write-protect sense in 5.25-inch mode |
| driveSense | input | 16 | 3.5-inch drive sense bits |
| phaseOut | output | 4 | Stepper phase lines |
| motorEnable | output | 1 | Controller motor enable, including the pending-off window |
| driveSel | output | 1 | Drive select |
| q6Out | output | 1 | Q6 mode line |
| q7Out | output | 1 | Q7 mode line |
| rdValid | output | 1 | Read data valid |
| rdData | output | 8 | Read data |
| cmdValid | output | 1 | 3.5-inch command strobe |
| cmdCode | output | 4 | Latched 3.5-inch command |
| motor35Run | output | 1 | 3.5-inch motor running |
| ctrlReset | output | 1 | Controller reset phase combination |
| auxEnable | output | 1 | Auxiliary-bus enable phase combination |

## Verification
The motor-off timer and the motor-on switch can act in the same cycle. In that case an offset-9 access carries the frame tick that would have expired the pending timeout. The bench provokes this directly and judges it at the ports: `motorEnable` must stay high after that edge and through the ticks that follow. A second collision is a phase 3 rise in 3.5-inch mode that also completes the phase 1 and 3 pair. This is judged by requiring `cmdValid` with the right code and `auxEnable` together.

// File: rtl/sw_dec_pkg.sv
package sw_dec_pkg;
  localparam int unsigned IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_MOTOR = 3'd4;
  localparam logic [IDX_W-1:0] IDX_DRIVE = 3'd5;
  localparam logic [IDX_W-1:0] IDX_Q6    = 3'd6;
  localparam logic [IDX_W-1:0] IDX_Q7    = 3'd7;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             val;
    logic             modeWr;
    logic             rdReq;
  } swStrobe_t;
endpackage

// File: rtl/sw_dec_ctrl.sv
module sw_dec_ctrl
  import sw_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              motorOn,
  input  logic              q6State,
  output swStrobe_t         strb
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = {ADDR_W{1'b1}};

  always_comb begin
    strb.hit    = accValid;
    strb.idx    = accAddr[ADDR_W-1:1];
    strb.val    = accAddr[0];
    strb.rdReq  = accValid && !accWrite;
    // mode register load: write to top offset, motor off, Q6 set (R4)
    strb.modeWr = accValid && accWrite && (accAddr == MODE_ADDR) && !motorOn && q6State;
  end
endmodule

// File: rtl/sw_dec_dp.sv
module sw_dec_dp
  import sw_dec_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PHASES    = 4,
  parameter int unsigned SENSE_W   = 16,
  parameter int unsigned OFF_TICKS = 60,
  parameter logic [3:0]  CMD_ON    = 4'h0,
  parameter logic [3:0]  CMD_OFF   = 4'h8
) (
  input  logic              clk,
  input  logic              rstN,
  input  swStrobe_t         strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sel35,
  input  logic              headSel,
  input  logic              frameTick,
  input  logic [DATA_W-1:0] rdByteIn,
  input  logic [DATA_W-1:0] hsByteIn,
  input  logic              wrProtect,
  input  logic [SENSE_W-1:0] driveSense,
  output logic [PHASES-1:0] phaseQ,
  output logic              motQ,
  output logic              drvQ,
  output logic              q6Q,
  output logic              q7Q,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              cmdValid,
  output logic [3:0]        cmdCode,
  output logic              m35Q,
  output logic              ctrlReset,
  output logic              auxEnable
);
  localparam int unsigned CNT_W = $clog2(OFF_TICKS + 1);
  localparam int unsigned SEL_W = $clog2(SENSE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OFF_TICKS - 1);

  logic [PHASES-1:0] phN;
  logic              drvN, q6N, q7N, motN, pendQ, pendN, m35N, ph3Rise;
  logic [CNT_W-1:0]  cntQ, cntN;
  logic [DATA_W-1:0] modeQ, modeN, statusByte, rdN;
  logic [3:0]        cmdN;
  logic [SEL_W-1:0]  senseIdx;
  logic              senseBit;

  assign ctrlReset = sel35 && phaseQ[0] && phaseQ[2];
  assign auxEnable = sel35 && phaseQ[1] && phaseQ[3];

  // switch bits
  always_comb begin
    phN  = phaseQ;
    drvN = drvQ;
    q6N  = q6Q;
    q7N  = q7Q;
    if (strb.hit) begin
      if (!strb.idx[IDX_W-1]) phN[strb.idx[1:0]] = strb.val;
      else if (strb.idx == IDX_DRIVE) drvN = strb.val;
      else if (strb.idx == IDX_Q6)    q6N  = strb.val;
      else if (strb.idx == IDX_Q7)    q7N  = strb.val;
    end
  end

  // motor with delayed off; an on-touch overrides a same-cycle expiry
  always_comb begin
    motN  = motQ;
    pendN = pendQ;
    cntN  = cntQ;
    if (strb.hit && strb.idx == IDX_MOTOR && strb.val) begin
      motN  = 1'b1;
      pendN = 1'b0;
      cntN  = '0;
    end else if (strb.hit && strb.idx == IDX_MOTOR) begin
      if (motQ) begin
        pendN = 1'b1;
        cntN  = '0;
      end
    end else if (pendQ && frameTick) begin
      if (cntQ == CNT_LAST) begin
        motN  = 1'b0;
        pendN = 1'b0;
        cntN  = '0;
      end else begin
        cntN = cntQ + 1'b1;
      end
    end
  end

  // command latch, mode register, read mux
  always_comb begin
    modeN   = ctrlReset ? '0 : (strb.modeWr ? wdata : modeQ);
    ph3Rise = sel35 && !phaseQ[3] && phN[3];
    cmdN    = {headSel, phaseQ[2:0]};
    m35N    = m35Q;
    if (ph3Rise && cmdN == CMD_ON)  m35N = 1'b1;
    if (ph3Rise && cmdN == CMD_OFF) m35N = 1'b0;
    senseIdx   = SEL_W'({headSel, phN[2:0]});
    senseBit   = sel35 ? driveSense[senseIdx] : wrProtect;
    statusByte = '0;
    statusByte[DATA_W-1] = senseBit;
    statusByte[DATA_W-3] = motN;
    if (motN) begin
      unique case ({q7N, q6N})
        2'b00:   rdN = rdByteIn;
        2'b10:   rdN = hsByteIn;
        default: rdN = statusByte;
      endcase
    end else begin
      rdN = q6N ? statusByte : modeN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= '0;
      drvQ     <= 1'b0;
      q6Q      <= 1'b0;
      q7Q      <= 1'b0;
      motQ     <= 1'b0;
      pendQ    <= 1'b0;
      cntQ     <= '0;
      modeQ    <= '0;
      m35Q     <= 1'b0;
      cmdValid <= 1'b0;
      cmdCode  <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
    end else begin
      phaseQ   <= phN;
      drvQ     <= drvN;
      q6Q      <= q6N;
      q7Q      <= q7N;
      motQ     <= motN;
      pendQ    <= pendN;
      cntQ     <= cntN;
      modeQ    <= modeN;
      m35Q     <= m35N;
      cmdValid <= ph3Rise;
      if (ph3Rise) cmdCode <= cmdN;
      rdValid  <= strb.rdReq;
      if (strb.rdReq) rdData <= rdN;
    end
  end

  p_cmd_on_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> phaseQ[3] && !$past(phaseQ[3]) && $past(sel35));
  p_reset_clears_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReset |=> modeQ == '0);
  p_pend_needs_motor_r8: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |-> motQ && cntQ < CNT_W'(OFF_TICKS));
  p_cancel_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hit && strb.idx == IDX_MOTOR && strb.val) |=> motQ && !pendQ);
  p_m35_by_cmd_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(m35Q) |-> cmdValid);
  p_rd_after_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strb.rdReq));
endmodule

// File: rtl/sw_phase_decoder.sv
module sw_phase_decoder
  import sw_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic [3:0]  accAddr,
  input  logic        accWrite,
  input  logic [7:0]  accWdata,
  input  logic        sel35,
  input  logic        headSel,
  input  logic        frameTick,
  input  logic [7:0]  rdByteIn,
  input  logic [7:0]  hsByteIn,
  input  logic        wrProtect,
  input  logic [15:0] driveSense,
  output logic [3:0]  phaseOut,
  output logic        motorEnable,
  output logic        driveSel,
  output logic        q6Out,
  output logic        q7Out,
  output logic        rdValid,
  output logic [7:0]  rdData,
  output logic        cmdValid,
  output logic [3:0]  cmdCode,
  output logic        motor35Run,
  output logic        ctrlReset,
  output logic        auxEnable
);
  swStrobe_t strb;

  sw_dec_ctrl #(.ADDR_W(4)) ctrl_i (
    .accValid(accValid), .accAddr(accAddr), .accWrite(accWrite),
    .motorOn(motorEnable), .q6State(q6Out), .strb(strb)
  );

  sw_dec_dp #(.DATA_W(8), .PHASES(4), .SENSE_W(16), .OFF_TICKS(60)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(accWdata), .sel35(sel35),
    .headSel(headSel), .frameTick(frameTick), .rdByteIn(rdByteIn),
    .hsByteIn(hsByteIn), .wrProtect(wrProtect), .driveSense(driveSense),
    .phaseQ(phaseOut), .motQ(motorEnable), .drvQ(driveSel), .q6Q(q6Out),
    .q7Q(q7Out), .rdValid(rdValid), .rdData(rdData), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .m35Q(motor35Run), .ctrlReset(ctrlReset),
    .auxEnable(auxEnable)
  );
endmodule

// File: tb/sw_phase_decoder_tb.sv
`timescale 1ns/1ps
module sw_phase_decoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0, sel35 = 1'b0, headSel = 1'b0;
  logic frameTick = 1'b0, wrProtect = 1'b0;
  logic [3:0] accAddr = '0;
  logic [7:0] accWdata = '0, rdByteIn = '0, hsByteIn = '0;
  logic [15:0] driveSense = '0;
  logic [3:0] phaseOut, cmdCode;
  logic motorEnable, driveSel, q6Out, q7Out, rdValid, cmdValid, motor35Run;
  logic ctrlReset, auxEnable;
  logic [7:0] rdData;

  int nRun = 0, nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sw_phase_decoder dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [3:0] a, input bit wr, input logic [7:0] wd, input bit tick);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accWrite = wr; accWdata = wd; frameTick = tick;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; frameTick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frameTick = 1'b1;
      @(negedge clk); frameTick = 1'b0;
    end
  endtask

  // expected status byte (R5)
  function automatic logic [7:0] expStatus(input bit s35, input bit hs, input logic [3:0] ph,
                                           input logic [15:0] sense, input bit wp, input bit mot);
    logic sb;
    sb = s35 ? sense[{hs, ph[2:0]}] : wp;
    return {sb, 1'b0, mot, 5'b0};
  endfunction

  // expected read byte with motor enabled (R3)
  function automatic logic [7:0] expRdOn(input bit q7, input bit q6, input logic [7:0] st,
                                         input logic [7:0] d, input logic [7:0] h);
    if (!q7 && !q6) return d;
    if (q7 && !q6)  return h;
    return st;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++; nRun++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [3:0] mPh;
    bit mDrv, mQ6, mQ7, mM35;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 phases", phaseOut, 0);
    chk("R11 motor", motorEnable, 0);
    chk("R11 drive/q6/q7", {driveSel, q6Out, q7Out}, 0);
    chk("R11 rdValid/cmdValid/m35", {rdValid, cmdValid, motor35Run}, 0);

    // R5 status with motor off, Q6 set (5.25 mode, write protect)
    wrProtect = 1'b1;
    acc(4'd13, 0, 0, 0);
    chk("R2 q6 set", q6Out, 1);
    chk("R3 rdValid", rdValid, 1);
    chk("R5 status motor off", rdData, 8'h80);
    // R4 mode load with motor off
    acc(4'd15, 1, 8'h1F, 0);
    chk("R2 q7 set", q7Out, 1);
    chk("R3 no rdValid on write", rdValid, 0);
    acc(4'd12, 0, 0, 0);
    chk("R4 mode readback", rdData, 8'h1F);

    // R7 reset combination clears mode; R6/R7 aux with command rise
    sel35 = 1'b1; headSel = 1'b0;
    acc(4'd1, 0, 0, 0);
    acc(4'd5, 0, 0, 0);
    chk("R1 phases 0,2", phaseOut, 4'b0101);
    chk("R7 ctrlReset", ctrlReset, 1);
    acc(4'd12, 0, 0, 0);
    chk("R7 mode cleared", rdData, 8'h00);
    acc(4'd3, 0, 0, 0);
    acc(4'd7, 0, 0, 0);
    chk("R6 cmdValid", cmdValid, 1);
    chk("R6 cmdCode", cmdCode, 4'h7);
    chk("R7 auxEnable", auxEnable, 1);
    chk("R10 code7 no motor", motor35Run, 0);
    acc(4'd0, 0, 0, 0); acc(4'd2, 0, 0, 0); acc(4'd4, 0, 0, 0); acc(4'd6, 0, 0, 0);
    chk("R7 idle", {ctrlReset, auxEnable}, 0);

    // R10 3.5 motor by command only
    acc(4'd9, 0, 0, 0);
    chk("R8 motor on", motorEnable, 1);
    chk("R10 offset 9 no 3.5 motor", motor35Run, 0);
    acc(4'd7, 0, 0, 0);
    chk("R6 code 0", {cmdValid, cmdCode}, 5'h10);
    chk("R10 cmd on", motor35Run, 1);
    acc(4'd7, 0, 0, 0);
    chk("R6 no pulse when ph3 on", cmdValid, 0);
    acc(4'd8, 0, 0, 0);
    chk("R10 offset 8 no effect", motor35Run, 1);
    acc(4'd9, 0, 0, 0);
    headSel = 1'b1;
    acc(4'd6, 0, 0, 0);
    acc(4'd7, 0, 0, 0);
    chk("R6 code 8", {cmdValid, cmdCode}, 5'h18);
    chk("R10 cmd off", motor35Run, 0);
    acc(4'd6, 0, 0, 0);
    sel35 = 1'b0; headSel = 1'b0;
    acc(4'd7, 0, 0, 0);
    chk("R6 none in 5.25 mode", cmdValid, 0);
    acc(4'd6, 0, 0, 0);

    // R4 write ignored while motor enabled
    acc(4'd13, 0, 0, 0);
    acc(4'd15, 1, 8'h05, 0);
    // R8 delayed off
    acc(4'd8, 0, 0, 0);
    chk("R8 pending keeps motor", motorEnable, 1);
    ticks(59);
    chk("R8 after 59 ticks", motorEnable, 1);
    ticks(1);
    chk("R8 after 60 ticks", motorEnable, 0);
    acc(4'd12, 0, 0, 0);
    chk("R4 write with motor on ignored", rdData, 8'h00);

    // R9 cancel
    acc(4'd9, 0, 0, 0);
    acc(4'd8, 0, 0, 0);
    ticks(30);
    acc(4'd9, 0, 0, 0);
    ticks(40);
    chk("R9 cancel mid-wait", motorEnable, 1);
    acc(4'd8, 0, 0, 0);
    ticks(59);
    acc(4'd9, 0, 0, 1);
    chk("R9 cancel on expiring tick", motorEnable, 1);
    ticks(5);
    chk("R9 stays on", motorEnable, 1);

    // R3 read map with motor on
    rdByteIn = 8'h96; hsByteIn = 8'h3C; wrProtect = 1'b1;
    acc(4'd14, 0, 0, 0);
    acc(4'd12, 0, 0, 0);
    chk("R3 data byte", rdData, 8'h96);
    acc(4'd13, 0, 0, 0);
    chk("R3 status motor on", rdData, 8'hA0);
    acc(4'd15, 0, 0, 0);
    chk("R3 status q7q6=11", rdData, 8'hA0);
    acc(4'd12, 0, 0, 0);
    chk("R3 handshake", rdData, 8'h3C);

    // random run from a fresh reset
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    acc(4'd9, 0, 0, 0);
    mPh = '0; mDrv = 0; mQ6 = 0; mQ7 = 0; mM35 = 0;
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      logic [3:0] old;
      bit wr, expCmd;
      logic [3:0] expCode;
      logic [7:0] st;
      a = 4'($urandom_range(0, 15));
      wr = ($urandom_range(0, 3) == 0);
      sel35 = 1'($urandom); headSel = 1'($urandom);
      wrProtect = 1'($urandom); rdByteIn = 8'($urandom);
      hsByteIn = 8'($urandom); driveSense = 16'($urandom);
      old = mPh;
      if (a[3] == 1'b0) mPh[a[2:1]] = a[0];
      else if (a[2:1] == 2'd1) mDrv = a[0];
      else if (a[2:1] == 2'd2) mQ6 = a[0];
      else if (a[2:1] == 2'd3) mQ7 = a[0];
      expCmd = sel35 && !old[3] && mPh[3];
      expCode = {headSel, old[2:0]};
      if (expCmd && expCode == 4'h0) mM35 = 1;
      if (expCmd && expCode == 4'h8) mM35 = 0;
      st = expStatus(sel35, headSel, mPh, driveSense, wrProtect, 1'b1);
      acc(a, wr, 8'($urandom), 0);
      chk("R1 random phases", phaseOut, mPh);
      chk("R2 random drive/q6/q7", {driveSel, q6Out, q7Out}, {mDrv, mQ6, mQ7});
      chk("R6 random cmdValid", cmdValid, expCmd);
      if (expCmd) chk("R6 random cmdCode", cmdCode, expCode);
      chk("R10 random 3.5 motor", motor35Run, mM35);
      chk("R7 random reset/aux", {ctrlReset, auxEnable},
          {sel35 && mPh[0] && mPh[2], sel35 && mPh[1] && mPh[3]});
      chk("R3 random rdValid", rdValid, !wr);
      if (!wr) chk("R3 random read", rdData, expRdOn(mQ7, mQ6, st, rdByteIn, hsByteIn));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule